// File: doc/BRIEF.md
# Byte/Word Selectable Parallel Flash Host Interface

This block sits between the external pins of a parallel NOR-style flash device and its internal logic. The host drives active-low chip select, read strobe and write strobe inputs, a byte/word width select, an active-low reset pin, an address bus and a 16-bit data bus. The block carries the bidirectional data bus as three ports: an input, an output and a per-lane drive-enable vector. All pin inputs are brought into the core clock domain through synchroniser chains of equal depth. The synchronised strobes are then edge-detected to form the internal latch points.

In word mode all sixteen data lanes carry data. In byte mode only the low eight lanes carry data, and the upper lanes never drive. The top data pin then acts as an extra address bit below the normal address bus. That bit picks the upper or lower byte of the 16-bit word that the array or status logic returns.

On a write, the block captures the address when the second of the two strobes goes low. It captures the data when the first of the two strobes returns high. After that it emits one single-cycle write pulse to the downstream command logic.

Top module: `flash_bus_if`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dq_oe`, `dq_out`, `wr_pulse`, `wr_addr` and `wr_data` are all zero.
- R2: Once the pins have settled for the synchroniser latency, `dq_oe[7:0]` is all ones exactly when `ce_n` is low, `oe_n` is low and `rp_n` is high. Otherwise it is all zeros.
- R3: When `word_mode` is 0 (byte mode), `dq_oe[15:8]` and `dq_out[15:8]` are zero.
- R4: When `word_mode` is 1 and the outputs are enabled, `dq_out` equals `rd_word` and all sixteen bits of `dq_oe` are set. `rd_addr` equals `{addr_in, 1'b0}`.
- R5: In byte mode with outputs enabled, `rd_addr` equals `{addr_in, dq_in[15]}`. `dq_out[7:0]` is `rd_word[15:8]` when `dq_in[15]` is 1 and `rd_word[7:0]` when it is 0.
- R6: While `rp_n` is low, all lanes float (`dq_oe` zero). A write strobe that is open when `rp_n` falls produces no `wr_pulse` and leaves `wr_data` unchanged.
- R7: `wr_addr` holds the address present when the later of `ce_n`/`we_n` falls. Its bit 0 is 0 in word mode.
- R8: `wr_data` holds the data present when the earlier of `ce_n`/`we_n` rises. Each write produces exactly one `wr_pulse` lasting one cycle, and `wr_data` changes only on a cycle when `wr_pulse` is high.
- R9: A write in which `we_n` is held low and `ce_n` is pulsed latches address and data in the same way as a write in which `we_n` is pulsed.
- R10: In byte mode a write gives `wr_data[15:8]` = 0, ignoring the upper data lanes. `wr_addr[0]` equals `dq_in[15]` at the address latch point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| word_mode | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| rp_n | input | 1 | Reset pin, active low; floats outputs and blocks writes |
| addr_in | input | ADDR_W | Address pins |
| dq_in | input | DATA_W | Data pins as seen by the input buffer |
| rd_word | input | DATA_W | Array or status word for `rd_addr` |
| dq_out | output | DATA_W | Data driven onto the pins |
| dq_oe | output | DATA_W | Per-lane drive enable |
| rd_addr | output | ADDR_W+1 | Synchronised read address with low byte-select bit |
| wr_pulse | output | 1 | One-cycle write strobe to the command logic |
| wr_addr | output | ADDR_W+1 | Latched write address with low byte-select bit |
| wr_data | output | DATA_W | Latched write data |

## Verification
The checker watches several properties on every cycle. It confirms that the upper lanes never drive or carry data in byte mode, and that the upper lanes never enable without the lower ones. It checks that a settled low reset pin floats every lane. It also checks that the write pulse is always one cycle wide and that the latched write data only moves together with it. Other behaviour depends on the order in which two asynchronous strobes move, and only the directed scenarios can show it. This covers address capture at the later falling edge, data capture at the earlier rising edge, chip-enable-controlled writes, byte-lane selection through the top data pin, and write cancellation by the reset pin.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  // Synchronised view of the single-bit control pins
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic wide;
    logic rp_n;
  } fbi_ctrl_t;

  localparam fbi_ctrl_t CTRL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      wide: 1'b1, rp_n: 1'b1};
endpackage

// File: rtl/fbi_sync.sv
module fbi_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[s] <= RST_VAL;
        end else begin
          if (s == 0) stg[s] <= d;
          else        stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fbi_wr_latch.sv
module fbi_wr_latch #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              rp_n,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              wr_pulse,
  output logic [ADDR_W:0]   wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HALF_W = DATA_W / 2;

  logic wact, wact_q;
  logic sub_bit;

  // Window where both strobes are low; its opening is the later falling
  // edge, its closing the earlier rising edge.
  assign wact    = ~ce_n & ~we_n & rp_n;
  assign sub_bit = wide ? 1'b0 : dq[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wact_q   <= 1'b0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wact_q   <= wact;
      wr_pulse <= 1'b0;
      if (wact && !wact_q) begin
        wr_addr <= {addr, sub_bit};
      end
      // rp_n low closes the window without a pulse
      if (!wact && wact_q && rp_n) begin
        wr_data  <= wide ? dq : {{(DATA_W-HALF_W){1'b0}}, dq[HALF_W-1:0]};
        wr_pulse <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbi_rd_steer.sv
module fbi_rd_steer #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              rp_n,
  input  logic              wide,
  input  logic              sub_bit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W:0]   rd_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);
  localparam int HALF_W = DATA_W / 2;

  logic              drive;
  logic [HALF_W-1:0] pick;

  assign drive   = ~ce_n & ~oe_n & rp_n;
  assign rd_addr = {addr, (wide ? 1'b0 : sub_bit)};
  assign pick    = sub_bit ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      dq_oe <= {{(DATA_W-HALF_W){drive & wide}}, {HALF_W{drive}}};
      if (!drive)    dq_out <= '0;
      else if (wide) dq_out <= rd_word;
      else           dq_out <= {{(DATA_W-HALF_W){1'b0}}, pick};
    end
  end
endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import fbi_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              word_mode,
  input  logic              rp_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [ADDR_W:0]   rd_addr,
  output logic              wr_pulse,
  output logic [ADDR_W:0]   wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CTRL_W = $bits(fbi_ctrl_t);
  localparam int BUS_W  = ADDR_W + DATA_W;

  fbi_ctrl_t          ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]   bus_s;
  logic [ADDR_W-1:0]  addr_s;
  logic [DATA_W-1:0]  dq_s;

  assign ctrl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                      wide: word_mode, rp_n: rp_n};

  // Controls and buses share the same depth so they stay aligned
  fbi_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
    .clk(clk), .rst(rst), .d(ctrl_raw), .q(ctrl_s)
  );

  fbi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr_in, dq_in}), .q(bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign dq_s   = bus_s[DATA_W-1:0];

  fbi_wr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .ce_n(ctrl_s.ce_n), .we_n(ctrl_s.we_n), .rp_n(ctrl_s.rp_n),
    .wide(ctrl_s.wide), .addr(addr_s), .dq(dq_s),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fbi_rd_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .ce_n(ctrl_s.ce_n), .oe_n(ctrl_s.oe_n), .rp_n(ctrl_s.rp_n),
    .wide(ctrl_s.wide), .sub_bit(dq_s[DATA_W-1]), .addr(addr_s),
    .rd_word(rd_word), .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/fbi_checker.sv
module fbi_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              word_mode,
  input logic              rp_n,
  input logic [DATA_W-1:0] dq_out,
  input logic [DATA_W-1:0] dq_oe,
  input logic              wr_pulse,
  input logic [DATA_W-1:0] wr_data
);
  localparam int HALF_W = DATA_W / 2;

  // R3: settled byte mode never drives upper lanes
  a_r3_byte_upper_float: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && !$past(word_mode) && !$past(word_mode, 2) && !$past(word_mode, 3))
      |-> (dq_oe[DATA_W-1:HALF_W] == '0));

  // R3: data on upper lanes only when those lanes are enabled
  a_r3_upper_quiet: assert property (@(posedge clk) disable iff (rst)
    (dq_out[DATA_W-1:HALF_W] != '0) |-> (dq_oe[DATA_W-1:HALF_W] != '0));

  // R2: upper lanes never enabled without the lower ones
  a_r2_lane_order: assert property (@(posedge clk) disable iff (rst)
    (dq_oe[DATA_W-1:HALF_W] != '0) |-> (&dq_oe[HALF_W-1:0]));

  // R6: settled reset pin floats all lanes
  a_r6_rp_float: assert property (@(posedge clk) disable iff (rst)
    (!rp_n && !$past(rp_n) && !$past(rp_n, 2) && !$past(rp_n, 3))
      |-> (dq_oe == '0));

  // R8: write pulse is a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

  // R8: write data moves only with the pulse
  a_r8_data_with_pulse: assert property (@(posedge clk) disable iff (rst)
    !wr_pulse |-> $stable(wr_data));
endmodule

bind flash_bus_if fbi_checker #(.DATA_W(DATA_W)) u_fbi_chk (
  .clk(clk), .rst(rst), .word_mode(word_mode), .rp_n(rp_n),
  .dq_out(dq_out), .dq_oe(dq_oe), .wr_pulse(wr_pulse), .wr_data(wr_data)
);

// File: tb/flash_bus_if_tb.sv
`timescale 1ns/1ps
module flash_bus_if_tb;
  localparam int AW = 18;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst;
  logic ce_n, oe_n, we_n, word_mode, rp_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] dq_in, rd_word;
  logic [DW-1:0] dq_out, dq_oe, wr_data;
  logic [AW:0]   rd_addr, wr_addr;
  logic          wr_pulse;

  int total = 0;
  int failed = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  flash_bus_if u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .rp_n(rp_n), .addr_in(addr_in), .dq_in(dq_in),
    .rd_word(rd_word), .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (!rst && wr_pulse) pulses++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; rp_n = 1;
    step(5);
  endtask

  task automatic t_reset();
    rst = 1; idle(); word_mode = 1; addr_in = '0; dq_in = '0; rd_word = '0;
    step(3);
    check("R1 dq_oe", dq_oe, 0);
    check("R1 dq_out", dq_out, 0);
    check("R1 wr_pulse", wr_pulse, 0);
    check("R1 wr_addr/wr_data", {wr_addr[15:0], wr_data}, 0);
    rst = 0;
    step(1);
    check("R1 post-release", {dq_oe, wr_data}, 0);
  endtask

  task automatic t_word_read();
    word_mode = 1; addr_in = 18'h12345; rd_word = 16'hBEEF; dq_in = 16'h8000;
    ce_n = 0; oe_n = 0; step(5);
    check("R4 word dq_out", dq_out, 32'hBEEF);
    check("R4 word dq_oe", dq_oe, 32'hFFFF);
    check("R4 word rd_addr", rd_addr, {18'h12345, 1'b0});
    check("R2 enabled low lanes", dq_oe[7:0], 32'hFF);
    idle();
  endtask

  task automatic t_byte_read();
    word_mode = 0; addr_in = 18'h0ABCD; rd_word = 16'hBEEF;
    dq_in = 16'h8000; ce_n = 0; oe_n = 0; step(5);
    check("R5 byte hi dq_out", dq_out, 32'h00BE);
    check("R5 byte hi rd_addr", rd_addr, {18'h0ABCD, 1'b1});
    check("R3 byte dq_oe", dq_oe, 32'h00FF);
    dq_in = 16'h0000; step(5);
    check("R5 byte lo dq_out", dq_out, 32'h00EF);
    check("R5 byte lo rd_addr", rd_addr, {18'h0ABCD, 1'b0});
    idle(); word_mode = 1; step(4);
  endtask

  task automatic t_gating();
    word_mode = 1; rd_word = 16'h1234; oe_n = 0; ce_n = 1; step(5);
    check("R2 deselected", dq_oe, 0);
    ce_n = 0; oe_n = 1; step(5);
    check("R2 oe high", dq_oe, 0);
    oe_n = 0; rp_n = 0; step(5);
    check("R6 rp low float", dq_oe, 0);
    rp_n = 1; step(5);
    check("R2 re-enabled", dq_oe, 32'hFFFF);
    idle();
  endtask

  task automatic t_we_write();
    int p0 = pulses;
    word_mode = 1; addr_in = 18'h00111; ce_n = 0; step(4);
    addr_in = 18'h22222; step(4);
    we_n = 0; dq_in = 16'hA55A; step(4);
    we_n = 1; step(4);
    dq_in = 16'h0F0F; ce_n = 1; step(5);
    check("R7 later falling edge addr", wr_addr, {18'h22222, 1'b0});
    check("R8 earlier rising edge data", wr_data, 32'hA55A);
    check("R8 one pulse", pulses - p0, 1);
    idle();
  endtask

  task automatic t_ce_write();
    int p0 = pulses;
    word_mode = 1; addr_in = 18'h00333; we_n = 0; step(4);
    addr_in = 18'h3C3C3; step(4);
    ce_n = 0; dq_in = 16'h6789; step(4);
    ce_n = 1; step(4);
    dq_in = 16'hFFFF; we_n = 1; step(5);
    check("R9 ce-controlled addr", wr_addr, {18'h3C3C3, 1'b0});
    check("R9 ce-controlled data", wr_data, 32'h6789);
    check("R9 one pulse", pulses - p0, 1);
    idle();
  endtask

  task automatic t_byte_write();
    int p0 = pulses;
    word_mode = 0; step(4);
    addr_in = 18'h01F0F; dq_in = 16'hFF3C; ce_n = 0; we_n = 0; step(4);
    we_n = 1; step(4);
    ce_n = 1; step(5);
    check("R10 byte addr lsb", wr_addr, {18'h01F0F, 1'b1});
    check("R10 byte data upper ignored", wr_data, 32'h003C);
    check("R10 one pulse", pulses - p0, 1);
    idle(); word_mode = 1; step(4);
  endtask

  task automatic t_rp_abort();
    int p0 = pulses;
    logic [DW-1:0] d0 = wr_data;
    word_mode = 1; addr_in = 18'h00777; dq_in = 16'h1111;
    ce_n = 0; we_n = 0; step(4);
    rp_n = 0; step(4);
    we_n = 1; ce_n = 1; step(5);
    check("R6 no pulse on aborted write", pulses - p0, 0);
    check("R6 wr_data unchanged", wr_data, d0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    t_reset();
    t_word_read();
    t_byte_read();
    t_gating();
    t_we_write();
    t_ce_write();
    t_byte_write();
    t_rp_abort();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule